// File: doc/BRIEF.md
# Pipelined Burst SRAM Front End

This block sits in front of a small single-port storage array and gives it a synchronous, pipelined interface. Every control, address and data input is registered on the rising clock edge. A read returns its word from an output register one clock after the address was taken, and a 2-bit burst counter generates up to four consecutive word addresses from one externally supplied address. Two address-start inputs open a burst. One is a processor-style start that always reads first and is masked by the primary select. The other is a controller-style start that reads or writes right away and is not masked. An advance input steps the burst or holds it in place to insert wait states.

Three select inputs allow depth expansion. A global write and per-lane write enables choose which byte lanes a write updates. An asynchronous output enable gates the data drivers. A sleep request, after a short entry latency, makes the block ignore its inputs and keeps the drivers off. The shared data bus is modelled as separate input, output and drive-enable signals. The burst order is chosen at the start of each burst: linear wrap or XOR interleave.

Top module: `bsram_front`

## Requirements
- R1: After reset `dOe` is low, no read is pending, and a continuation cycle without a prior start does nothing.
- R2: `startAN` low with `selN` low and the secondary selects on loads `addrIn` and performs a read, even if write enables are low in that cycle. A write to that address happens only if write enables are asserted on the next edge, with `stepN` high.
- R3: `startAN` is ignored while `selN` is high: the cycle behaves as if no start were present. `startBN` low is not masked by `selN`. With all selects on, it reads or writes at `addrIn` according to the write enables of that same cycle.
- R4: `selHi` (active high) and `selLoN` (active low) matter only on cycles where a start is accepted. Any select off on such a cycle is a deselect that ends the burst. On other cycles they have no effect.
- R5: On a cycle with no start and an open burst, `stepN` low moves the burst counter to the next address; `stepN` high repeats the current address. Both reads and writes follow the resulting address.
- R6: With `interleave` low at the start, the low two address bits go through (base+i) mod 4 for i = 0..3.
- R7: With `interleave` high at the start, the low two address bits go through base XOR i; for example base 01 gives 01, 00, 11, 10. The order is fixed for the burst at the start cycle.
- R8: `allWrN` low writes every byte lane. Otherwise, `laneGateN` low writes each lane k whose `laneWrN[k]` is low, where lane k is bits 8k+7..8k. When none of these is active the cycle is a read.
- R9: Read data sampled at edge N is driven from edge N+1 onward. `outEnN` high turns the drivers off immediately, without waiting for a clock.
- R10: A deselect taken at edge N leaves the previous read visible until edge N+1, after which `dOe` stays low.
- R11: `sleepReq` high forces `dOe` low at once. Inputs on the first two edges with `sleepReq` high are still accepted; from the third edge on they are ignored and the burst is closed. After `sleepReq` falls, inputs on the next two edges are ignored and the third edge samples them again.
- R12: A burst changes only the low two address bits and wraps within them. The upper bits stay as loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addrIn | input | AW | External word address |
| startAN | input | 1 | Processor-style burst start, active low |
| startBN | input | 1 | Controller-style burst start, active low |
| stepN | input | 1 | Burst advance, active low |
| interleave | input | 1 | Burst order select: 0 linear, 1 interleaved |
| selN | input | 1 | Primary select, active low |
| selHi | input | 1 | Secondary select, active high |
| selLoN | input | 1 | Secondary select, active low |
| allWrN | input | 1 | Write all lanes, active low |
| laneGateN | input | 1 | Enables per-lane writes, active low |
| laneWrN | input | NB | Per-lane write enables, active low |
| outEnN | input | 1 | Asynchronous output enable, active low |
| sleepReq | input | 1 | Sleep request, active high |
| dIn | input | DW | Write data |
| dOut | output | DW | Read data from the output register |
| dOe | output | 1 | Data bus drive enable |

## Verification
The assertions assume that a burst is opened only through an accepted start. They also assume that the upper address bits and the burst order never change during a burst, and that reset is held only at the start of a run. The random part of the bench keeps to the one rule the block relies on: after an accepted processor-style start, the following cycle has `stepN` high. Every other input, including sleep, selects and write enables, is drawn freely. A cycle-level model in the bench tracks the burst state, the two-stage pipeline and the array contents, and predicts `dOe` and `dOut` at every falling edge.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  // Command handed from the control to the datapath for one cycle.
  typedef struct packed {
    logic rd;
    logic wr;
  } cmd_t;
endpackage

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
  import bsram_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] addrIn,
  input  logic          startAN,
  input  logic          startBN,
  input  logic          stepN,
  input  logic          interleave,
  input  logic          selN,
  input  logic          selHi,
  input  logic          selLoN,
  input  logic          allWrN,
  input  logic          laneGateN,
  input  logic [NB-1:0] laneWrN,
  input  logic          sleepReq,
  output cmd_t          cmd,
  output logic [AW-1:0] cmdAddr,
  output logic [NB-1:0] cmdMask,
  output logic          sleepHold
);
  localparam int UW = AW - 2;

  logic          sleepQ1, sleepQ2;
  logic          activeQ, modeQ;
  logic [UW-1:0] upperQ;
  logic [1:0]    baseQ, cntQ, cntNext, lowBits;
  logic          procHit, strobeCyc, chipOn, wrAny;
  logic [NB-1:0] laneMask;

  assign sleepHold = sleepQ2;
  assign procHit   = !startAN && !selN;
  assign strobeCyc = !sleepHold && (procHit || !startBN);
  assign chipOn    = !selN && selHi && !selLoN;
  assign laneMask  = !allWrN ? {NB{1'b1}} : (!laneGateN ? ~laneWrN : '0);
  assign wrAny     = |laneMask;
  assign cntNext   = stepN ? cntQ : cntQ + 2'd1;
  assign lowBits   = modeQ ? (baseQ ^ cntNext) : (baseQ + cntNext);

  always_comb begin
    cmd     = '0;
    cmdAddr = {upperQ, lowBits};
    if (strobeCyc) begin
      if (chipOn) begin
        cmdAddr = addrIn;
        cmd.wr  = !procHit && wrAny;
        cmd.rd  = !cmd.wr;
      end
    end else if (!sleepHold && activeQ) begin
      cmd.wr = wrAny;
      cmd.rd = !wrAny;
    end
    cmdMask = cmd.wr ? laneMask : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sleepQ1 <= 1'b0;
      sleepQ2 <= 1'b0;
      activeQ <= 1'b0;
      modeQ   <= 1'b0;
      upperQ  <= '0;
      baseQ   <= '0;
      cntQ    <= '0;
    end else begin
      sleepQ1 <= sleepReq;
      sleepQ2 <= sleepQ1;
      if (sleepHold) begin
        activeQ <= 1'b0;
      end else if (strobeCyc) begin
        activeQ <= chipOn;
        if (chipOn) begin
          upperQ <= addrIn[AW-1:2];
          baseQ  <= addrIn[1:0];
          cntQ   <= '0;
          modeQ  <= interleave;
        end
      end else if (activeQ) begin
        cntQ <= cntNext;
      end
    end
  end

  // R2
  proc_start_reads_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sleepHold && procHit && selHi && !selLoN) |-> (cmd.rd && !cmd.wr));

  // R4
  deselect_no_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sleepHold && !startBN && (selN || !selHi || selLoN)) |-> (!cmd.rd && !cmd.wr));

  // R12
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ && !strobeCyc && !sleepHold) |-> (cmdAddr[AW-1:2] == $past(cmdAddr[AW-1:2])));
endmodule

// File: rtl/bsram_dp.sv
module bsram_dp
  import bsram_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 32,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  cmd_t          cmd,
  input  logic [AW-1:0] cmdAddr,
  input  logic [NB-1:0] cmdMask,
  input  logic [DW-1:0] dIn,
  input  logic          outEnN,
  input  logic          sleepReq,
  input  logic          sleepHold,
  output logic [DW-1:0] dOut,
  output logic          dOe
);
  localparam int BW    = DW / NB;
  localparam int DEPTH = 1 << AW;

  cmd_t          cmdQ;
  logic [AW-1:0] addrQ;
  logic [NB-1:0] maskQ;
  logic [DW-1:0] dataQ, outDataQ;
  logic          outValidQ;
  logic [DW-1:0] mem [DEPTH];

  // Input stage: everything captured on the edge that accepts the command.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ      <= '0;
      addrQ     <= '0;
      maskQ     <= '0;
      dataQ     <= '0;
      outValidQ <= 1'b0;
      outDataQ  <= '0;
    end else begin
      cmdQ      <= cmd;
      addrQ     <= cmdAddr;
      maskQ     <= cmdMask;
      dataQ     <= dIn;
      outValidQ <= cmdQ.rd;
      if (cmdQ.rd) outDataQ <= mem[addrQ];
    end
  end

  // Array stage: one operation per cycle, write lanes picked by the mask.
  always_ff @(posedge clk) begin
    if (cmdQ.wr) begin
      for (int k = 0; k < NB; k++) begin
        if (maskQ[k]) mem[addrQ][k*BW +: BW] <= dataQ[k*BW +: BW];
      end
    end
  end

  assign dOut = outDataQ;
  assign dOe  = outValidQ && !outEnN && !sleepReq && !sleepHold;

  // R10
  single_deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdQ.rd |=> !dOe);

  // R8
  write_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdQ.wr |=> !dOe);
endmodule

// File: rtl/bsram_front.sv
module bsram_front
  import bsram_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 32,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] addrIn,
  input  logic          startAN,
  input  logic          startBN,
  input  logic          stepN,
  input  logic          interleave,
  input  logic          selN,
  input  logic          selHi,
  input  logic          selLoN,
  input  logic          allWrN,
  input  logic          laneGateN,
  input  logic [NB-1:0] laneWrN,
  input  logic          outEnN,
  input  logic          sleepReq,
  input  logic [DW-1:0] dIn,
  output logic [DW-1:0] dOut,
  output logic          dOe
);
  cmd_t          cmd;
  logic [AW-1:0] cmdAddr;
  logic [NB-1:0] cmdMask;
  logic          sleepHold;

  bsram_ctrl #(.AW(AW), .NB(NB)) uCtrl (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .startAN(startAN), .startBN(startBN),
    .stepN(stepN), .interleave(interleave), .selN(selN), .selHi(selHi), .selLoN(selLoN),
    .allWrN(allWrN), .laneGateN(laneGateN), .laneWrN(laneWrN), .sleepReq(sleepReq),
    .cmd(cmd), .cmdAddr(cmdAddr), .cmdMask(cmdMask), .sleepHold(sleepHold)
  );

  bsram_dp #(.AW(AW), .DW(DW), .NB(NB)) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .cmdAddr(cmdAddr), .cmdMask(cmdMask), .dIn(dIn),
    .outEnN(outEnN), .sleepReq(sleepReq), .sleepHold(sleepHold), .dOut(dOut), .dOe(dOe)
  );
endmodule

// File: tb/tb_bsram_front.sv
`timescale 1ns/1ps
module tb_bsram_front;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  aIn = '0;
  logic        sAN = 1'b1, sBN = 1'b1, stN = 1'b1, ilv = 1'b0;
  logic        sel = 1'b0, selH = 1'b1, selL = 1'b0;
  logic        awN = 1'b1, lgN = 1'b1;
  logic [3:0]  lwN = 4'hF;
  logic        oeN = 1'b0, slp = 1'b0;
  logic [31:0] din = '0;
  logic [31:0] dOut;
  logic        dOe;

  int errors = 0, checks = 0;
  bit done = 0;
  string curReq = "R1";

  // Bench-side model state
  logic [31:0] mMem [0:63];
  logic        mS1 = 0, mS2 = 0, mAct = 0, mMd = 0;
  logic [3:0]  mUp = '0;
  logic [1:0]  mBase = '0, mCnt = '0;
  logic        s1Rd = 0, s1Wr = 0;
  logic [5:0]  s1Addr = '0;
  logic [3:0]  s1Mask = '0;
  logic [31:0] s1Data = '0;
  logic        oValid = 0;
  logic [31:0] oData = '0;

  always #2 clk = ~clk;

  bsram_front dut (
    .clk(clk), .rstN(rstN), .addrIn(aIn), .startAN(sAN), .startBN(sBN), .stepN(stN),
    .interleave(ilv), .selN(sel), .selHi(selH), .selLoN(selL), .allWrN(awN),
    .laneGateN(lgN), .laneWrN(lwN), .outEnN(oeN), .sleepReq(slp), .dIn(din),
    .dOut(dOut), .dOe(dOe)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  task automatic modelEdge();
    logic [3:0] mk;
    logic procHit, strb, nRd, nWr;
    logic [5:0] nAddr;
    logic gateM;
    gateM = mS2;
    if (s1Wr)
      for (int b = 0; b < 4; b++) if (s1Mask[b]) mMem[s1Addr][b*8 +: 8] = s1Data[b*8 +: 8];
    oValid = s1Rd;
    if (s1Rd) oData = mMem[s1Addr];
    mk = !awN ? 4'hF : (!lgN ? ~lwN : 4'h0);
    procHit = !sAN && !sel;
    strb = !gateM && (procHit || !sBN);
    nRd = 0; nWr = 0; nAddr = '0;
    if (strb) begin
      if (!sel && selH && !selL) begin
        mAct = 1; mUp = aIn[5:2]; mBase = aIn[1:0]; mCnt = 0; mMd = ilv;
        nWr = !procHit && (|mk); nRd = !nWr; nAddr = aIn;
      end else mAct = 0;
    end else if (gateM) begin
      mAct = 0;
    end else if (mAct) begin
      if (!stN) mCnt = mCnt + 2'd1;
      nAddr = {mUp, (mMd ? (mBase ^ mCnt) : (mBase + mCnt))};
      nWr = |mk; nRd = !nWr;
    end
    s1Rd = nRd; s1Wr = nWr; s1Addr = nAddr; s1Mask = mk; s1Data = din;
    mS2 = mS1; mS1 = slp;
  endtask

  task automatic compareOut();
    logic expOe;
    expOe = oValid && !oeN && !slp && !mS2;
    check(dOe == expOe, curReq, {31'd0, dOe}, {31'd0, expOe});
    if (dOe && expOe) check(dOut == oData, curReq, dOut, oData);
  endtask

  task automatic step();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compareOut();
  endtask

  task automatic idle();
    sAN = 1; sBN = 1; stN = 1; awN = 1; lgN = 1; lwN = 4'hF;
    sel = 0; selH = 1; selL = 0;
  endtask

  task automatic expectWord(input logic [31:0] exp, input string req);
    check(dOe == 1'b1, req, {31'd0, dOe}, 32'd1);
    check(dOut == exp, req, dOut, exp);
  endtask

  task automatic burstRead(input logic [5:0] a, input logic md, input string req);
    logic [1:0] lo;
    idle(); ilv = md; aIn = a; sAN = 0; step();
    idle(); stN = 0;
    for (int i = 0; i < 4; i++) begin
      if (i == 3) stN = 1;
      step();
      lo = md ? (a[1:0] ^ 2'(i)) : (a[1:0] + 2'(i));
      expectWord(mMem[{a[5:2], lo}], req);
    end
    step();
    lo = md ? (a[1:0] ^ 2'd3) : (a[1:0] + 2'd3);
    expectWord(mMem[{a[5:2], lo}], "R5");
  endtask

  initial begin
    logic [31:0] oldV, v;
    void'($urandom(32'h5EED_2024));
    for (int i = 0; i < 64; i++) mMem[i] = '0;
    // R1 reset
    curReq = "R1";
    repeat (3) @(negedge clk);
    check(dOe == 1'b0, "R1", {31'd0, dOe}, 32'd0);
    rstN = 1;
    stN = 0; step(); step();
    check(dOe == 1'b0, "R1", {31'd0, dOe}, 32'd0);
    // R5 fill every word with bursts of writes
    curReq = "R5";
    for (int b = 0; b < 16; b++) begin
      idle(); aIn = 6'(b * 4); sBN = 0; awN = 0; din = $urandom; step();
      for (int i = 0; i < 3; i++) begin
        idle(); stN = 0; awN = 0; din = $urandom; step();
      end
    end
    idle(); sBN = 0; selH = 0; step(); idle(); step(); step();
    // R6 / R7 / R12 order checks
    curReq = "R6"; burstRead(6'h06, 1'b0, "R6");
    curReq = "R7"; burstRead(6'h11, 1'b1, "R7");
    curReq = "R12"; burstRead(6'h2F, 1'b0, "R12");
    // R2 processor start reads, writes on next edge
    curReq = "R2";
    oldV = mMem[9];
    idle(); aIn = 6'd9; sAN = 0; awN = 0; din = 32'h1111_2222; step();
    idle(); awN = 0; din = 32'hCAFE_0009; step();
    expectWord(oldV, "R2");
    idle(); step();
    check(dOe == 1'b0, "R2", {31'd0, dOe}, 32'd0);
    step();
    expectWord(32'hCAFE_0009, "R2");
    // R8 lane write and plain read
    curReq = "R8";
    oldV = mMem[20];
    idle(); aIn = 6'd20; sBN = 0; lgN = 0; lwN = 4'b1110; din = 32'hAABB_CCDD; step();
    idle(); step(); step();
    expectWord({oldV[31:8], 8'hDD}, "R8");
    oldV = mMem[21];
    idle(); aIn = 6'd21; sBN = 0; lgN = 1; lwN = 4'h0; step();
    idle(); step();
    expectWord(oldV, "R8");
    // R9 asynchronous output enable
    curReq = "R9";
    oeN = 1; #0.5;
    check(dOe == 1'b0, "R9", {31'd0, dOe}, 32'd0);
    oeN = 0; #0.5;
    check(dOe == 1'b1, "R9", {31'd0, dOe}, 32'd1);
    // R3 / R4 / R10
    curReq = "R3";
    idle(); aIn = 6'd30; sBN = 0; step(); idle(); step();
    idle(); sAN = 0; sel = 1; step();
    expectWord(mMem[30], "R3");
    curReq = "R4";
    idle(); selH = 0; selL = 1; step();
    expectWord(mMem[30], "R4");
    curReq = "R10";
    idle(); sBN = 0; sel = 1; step();
    expectWord(mMem[30], "R10");
    idle(); step();
    check(dOe == 1'b0, "R10", {31'd0, dOe}, 32'd0);
    curReq = "R3";
    idle(); sAN = 0; sel = 1; step(); step();
    check(dOe == 1'b0, "R3", {31'd0, dOe}, 32'd0);
    // R11 sleep
    curReq = "R11";
    idle(); aIn = 6'd40; sBN = 0; step(); idle(); step();
    slp = 1; #0.5;
    check(dOe == 1'b0, "R11", {31'd0, dOe}, 32'd0);
    oldV = mMem[41];
    step(); step();
    idle(); aIn = 6'd41; sBN = 0; awN = 0; din = 32'hDEAD_0041; step();
    idle(); step(); step();
    slp = 0;
    idle(); aIn = 6'd41; sBN = 0; awN = 0; din = 32'hDEAD_1041; step(); step();
    idle(); aIn = 6'd41; sBN = 0; step(); idle(); step();
    expectWord(oldV, "R11");
    idle(); aIn = 6'd42; sBN = 0; awN = 0; din = 32'h0042_BEEF; step();
    idle(); aIn = 6'd42; sBN = 0; step(); idle(); step();
    expectWord(32'h0042_BEEF, "R11");
    // Random traffic, R9 timing checked against the model every cycle
    curReq = "R9";
    begin
      bit lastProc = 0;
      for (int c = 0; c < 2000; c++) begin
        v = $urandom;
        idle();
        aIn = 6'($urandom);
        sAN = (v[2:0] != 0);
        sBN = (v[5:3] != 0);
        stN = lastProc ? 1'b1 : v[6];
        ilv = v[7];
        sel = (v[11:8] == 0);
        selH = (v[15:12] != 0);
        selL = (v[19:16] == 0);
        awN = (v[22:20] != 0);
        lgN = v[23];
        lwN = 4'($urandom);
        oeN = (v[26:24] == 0);
        if (v[31:27] == 0) slp = ~slp;
        din = $urandom;
        lastProc = !sAN && !sel && !mS2;
        step();
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule